// File: doc/BRIEF.md
# Interlaced YCbCr Test-Pattern Source

This block drives an interlaced 4:2:2 video stream onto a 16-bit parallel bus for a downstream capture front end. One byte lane carries luma; the other carries chroma, alternating blue-difference and red-difference samples. Both are sampled on a free-running pixel clock (nominally 54 MHz). Each frame is sent as two fields: even first, then odd, then the next frame's even field. Each field opens with its own vertical sync pulse, and every line opens with a horizontal sync pulse. A field output shows which field is being sent.

Line and field blanking, sync pulse widths and sync polarity are parameters. Outside the active window the data lanes carry fixed black levels. A data-enable output marks active samples only. Pixel values come from an arithmetic test pattern, so a receiver can check that every sample landed in the right place.

Top module: `yc_field_source`

## Requirements
- R1: While reset is held, hsync and vsync sit at their inactive levels, de is 0, field is 0, luma is 0x10 and chroma is 0x80.
- R2: Every line is HBLANK+ACT_W clocks long. Each line starts with an hsync pulse lasting exactly HS_W clocks.
- R3: On each active line, de is high for exactly ACT_W consecutive clocks. The first of them comes HBLANK clocks after the hsync leading edge.
- R4: Each field is VBLANK+ACT_LINES/2 lines long. Its vsync pulse starts on the same clock as that field's first hsync and lasts VS_W clocks.
- R5: The first VBLANK lines of a field carry no active samples. The remaining ACT_LINES/2 lines are all active.
- R6: field is 0 for an even field and 1 for an odd field. It changes only where a vsync pulse starts, and it alternates. The first field after reset is even.
- R7: Whenever de is 0, luma is 0x10 and chroma is 0x80.
- R8: On the chroma lane, active sample p of a line carries Cb = {2'b01, fl[5:0]} when p is even and Cr = {2'b11, fl[5:0]} when p is odd. Every line therefore starts with Cb. Here fl = 2*a + field is the frame line number, and a is the active-line index within the field.
- R9: Active sample p of frame line fl has luma (p + fl) mod 256.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Continuously running pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync | output | 1 | Line sync, active level HS_ACT |
| vsync | output | 1 | Field sync, active level VS_ACT |
| field | output | 1 | 0 during an even field, 1 during an odd field |
| de | output | 1 | High on active samples only |
| luma | output | 8 | Luma lane |
| chroma | output | 8 | Interleaved Cb/Cr lane |

## Verification
The only inputs are the clock and the reset. The assertions assume the reset is held low from time zero for at least one clock edge, so the registered outputs start from a known level. They also assume HS_W and VS_W are both smaller than HBLANK. The bench keeps within these limits: it holds reset for several cycles from the start, and it uses a small configuration with short blanking and narrow pulses. It then releases reset and observes the stream free-running for more than four fields.

// File: rtl/yfs_pkg.sv
package yfs_pkg;

    localparam logic [7:0] BLANK_LUMA   = 8'h10;
    localparam logic [7:0] BLANK_CHROMA = 8'h80;

    typedef struct packed {
        logic       hs;
        logic       vs;
        logic       fld;
        logic       de;
        logic [7:0] luma;
        logic [7:0] chroma;
    } yfs_pix_t;

endpackage

// File: rtl/yfs_timing.sv
module yfs_timing #(
    parameter int ACT_W  = 1280,
    parameter int FLINES = 480,
    parameter int HBLANK = 370,
    parameter int VBLANK = 22,
    parameter int HW     = 11,
    parameter int VW     = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [HW-1:0] hpos,
    output logic [VW-1:0] vline,
    output logic          odd
);
    localparam logic [HW-1:0] H_LAST = HW'(HBLANK + ACT_W - 1);
    localparam logic [VW-1:0] V_LAST = VW'(VBLANK + FLINES - 1);

    typedef struct packed {
        logic [HW-1:0] h;
        logic [VW-1:0] v;
        logic          odd;
    } tm_t;

    tm_t tm_d, tm_q;

    always_comb begin
        tm_d = tm_q;
        if (tm_q.h == H_LAST) begin
            tm_d.h = '0;
            if (tm_q.v == V_LAST) begin
                tm_d.v   = '0;
                tm_d.odd = ~tm_q.odd;
            end else begin
                tm_d.v = tm_q.v + 1'b1;
            end
        end else begin
            tm_d.h = tm_q.h + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tm_q <= '0;
        end else begin
            tm_q <= tm_d;
        end
    end

    assign hpos  = tm_q.h;
    assign vline = tm_q.v;
    assign odd   = tm_q.odd;

endmodule

// File: rtl/yfs_lanes.sv
module yfs_lanes
    import yfs_pkg::*;
#(
    parameter int   HBLANK = 370,
    parameter int   VBLANK = 22,
    parameter int   HS_W   = 16,
    parameter int   VS_W   = 16,
    parameter logic HS_ACT = 1'b1,
    parameter logic VS_ACT = 1'b1,
    parameter int   HW     = 11,
    parameter int   VW     = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [HW-1:0] hpos,
    input  logic [VW-1:0] vline,
    input  logic          odd,
    output yfs_pix_t      pix
);
    localparam logic [HW-1:0] HB_C  = HW'(HBLANK);
    localparam logic [HW-1:0] HSW_C = HW'(HS_W);
    localparam logic [HW-1:0] VSW_C = HW'(VS_W);
    localparam logic [VW-1:0] VB_C  = VW'(VBLANK);

    yfs_pix_t pix_d, pix_q;
    logic [VW-1:0] act_line;
    logic [7:0]    px8;
    logic [7:0]    fl8;
    logic          hs_on, vs_on, de_on;

    always_comb begin
        hs_on    = (hpos < HSW_C);
        vs_on    = (vline == '0) && (hpos < VSW_C);
        de_on    = (hpos >= HB_C) && (vline >= VB_C);
        act_line = vline - VB_C;
        px8      = 8'(hpos - HB_C);
        fl8      = 8'({act_line, odd});

        pix_d.hs  = hs_on ? HS_ACT : ~HS_ACT;
        pix_d.vs  = vs_on ? VS_ACT : ~VS_ACT;
        pix_d.fld = odd;
        pix_d.de  = de_on;
        if (de_on) begin
            pix_d.luma   = px8 + fl8;
            pix_d.chroma = px8[0] ? {2'b11, fl8[5:0]} : {2'b01, fl8[5:0]};
        end else begin
            pix_d.luma   = BLANK_LUMA;
            pix_d.chroma = BLANK_CHROMA;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_q.hs     <= ~HS_ACT;
            pix_q.vs     <= ~VS_ACT;
            pix_q.fld    <= 1'b0;
            pix_q.de     <= 1'b0;
            pix_q.luma   <= BLANK_LUMA;
            pix_q.chroma <= BLANK_CHROMA;
        end else begin
            pix_q <= pix_d;
        end
    end

    assign pix = pix_q;

endmodule

// File: rtl/yc_field_source.sv
module yc_field_source
    import yfs_pkg::*;
#(
    parameter int   ACT_W     = 1280,
    parameter int   ACT_LINES = 960,
    parameter int   HBLANK    = 370,
    parameter int   VBLANK    = 22,
    parameter int   HS_W      = 16,
    parameter int   VS_W      = 16,
    parameter logic HS_ACT    = 1'b1,
    parameter logic VS_ACT    = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    output logic       hsync,
    output logic       vsync,
    output logic       field,
    output logic       de,
    output logic [7:0] luma,
    output logic [7:0] chroma
);
    localparam int FLINES = ACT_LINES / 2;
    localparam int HW     = $clog2(HBLANK + ACT_W);
    localparam int VW     = $clog2(VBLANK + FLINES);

    logic [HW-1:0] hpos;
    logic [VW-1:0] vline;
    logic          odd;
    yfs_pix_t      pix;

    yfs_timing #(
        .ACT_W (ACT_W),
        .FLINES(FLINES),
        .HBLANK(HBLANK),
        .VBLANK(VBLANK),
        .HW    (HW),
        .VW    (VW)
    ) u_timing (
        .clk  (clk),
        .rst_n(rst_n),
        .hpos (hpos),
        .vline(vline),
        .odd  (odd)
    );

    yfs_lanes #(
        .HBLANK(HBLANK),
        .VBLANK(VBLANK),
        .HS_W  (HS_W),
        .VS_W  (VS_W),
        .HS_ACT(HS_ACT),
        .VS_ACT(VS_ACT),
        .HW    (HW),
        .VW    (VW)
    ) u_lanes (
        .clk  (clk),
        .rst_n(rst_n),
        .hpos (hpos),
        .vline(vline),
        .odd  (odd),
        .pix  (pix)
    );

    assign hsync  = pix.hs;
    assign vsync  = pix.vs;
    assign field  = pix.fld;
    assign de     = pix.de;
    assign luma   = pix.luma;
    assign chroma = pix.chroma;

endmodule

// File: rtl/yfs_check.sv
module yfs_check #(
    parameter int   HS_W   = 16,
    parameter int   VS_W   = 16,
    parameter logic HS_ACT = 1'b1,
    parameter logic VS_ACT = 1'b1
) (
    input logic       clk,
    input logic       rst_n,
    input logic       hsync,
    input logic       vsync,
    input logic       field,
    input logic       de,
    input logic [7:0] luma,
    input logic [7:0] chroma
);
    logic        hs_a, vs_a;
    logic [15:0] hs_run, vs_run;

    assign hs_a = (hsync == HS_ACT);
    assign vs_a = (vsync == VS_ACT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_run <= '0;
            vs_run <= '0;
        end else begin
            hs_run <= hs_a ? hs_run + 16'd1 : '0;
            vs_run <= vs_a ? vs_run + 16'd1 : '0;
        end
    end

    AST_HS_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (!hs_a && $past(hs_a)) |-> (hs_run == 16'(HS_W))); // R2
    AST_VS_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (!vs_a && $past(vs_a)) |-> (vs_run == 16'(VS_W))); // R4
    AST_VS_ON_LINE_START: assert property (@(posedge clk) disable iff (!rst_n)
        (vs_a && !$past(vs_a)) |-> (hs_a && !$past(hs_a))); // R4
    AST_NO_DE_IN_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        hs_a |-> !de); // R3
    AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(vs_a && !$past(vs_a)) |-> $stable(field)); // R6
    AST_BLANK_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
        !de |-> (luma == 8'h10 && chroma == 8'h80)); // R7
    AST_CB_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(de) |-> (chroma[7:6] == 2'b01)); // R8
    AST_CHROMA_ALT: assert property (@(posedge clk) disable iff (!rst_n)
        (de && $past(de)) |-> (chroma[7] != $past(chroma[7]))); // R8

endmodule

bind yc_field_source yfs_check #(
    .HS_W  (HS_W),
    .VS_W  (VS_W),
    .HS_ACT(HS_ACT),
    .VS_ACT(VS_ACT)
) u_yfs_check (
    .clk   (clk),
    .rst_n (rst_n),
    .hsync (hsync),
    .vsync (vsync),
    .field (field),
    .de    (de),
    .luma  (luma),
    .chroma(chroma)
);

// File: tb/yc_field_source_bench.sv
module yc_field_source_bench;
    localparam int ACT_W     = 8;
    localparam int ACT_LINES = 6;
    localparam int HBLANK    = 4;
    localparam int VBLANK    = 2;
    localparam int HS_W      = 2;
    localparam int VS_W      = 3;
    localparam int FLINES    = ACT_LINES / 2;
    localparam int HTOT      = HBLANK + ACT_W;
    localparam int VTOT      = VBLANK + FLINES;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hsync, vsync, field, de;
    logic [7:0] luma, chroma;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;
    bit  mon_en = 1'b0;

    always #2.5 clk = ~clk;

    yc_field_source #(
        .ACT_W    (ACT_W),
        .ACT_LINES(ACT_LINES),
        .HBLANK   (HBLANK),
        .VBLANK   (VBLANK),
        .HS_W     (HS_W),
        .VS_W     (VS_W),
        .HS_ACT   (1'b1),
        .VS_ACT   (1'b1)
    ) u_yc_field_source (
        .clk   (clk),
        .rst_n (rst_n),
        .hsync (hsync),
        .vsync (vsync),
        .field (field),
        .de    (de),
        .luma  (luma),
        .chroma(chroma)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // stream monitor state
    int cyc = 0, last_hs = 0, last_vs = 0;
    int hpos = 0, de_cnt = 0, lidx = 0, act_lines = 0, fields = 0;
    bit prev_hs = 0, prev_vs = 0, have_line = 0, have_field = 0;
    bit fld_exp = 0;

    always @(negedge clk) begin
        if (mon_en) begin
            bit hs_rise, vs_rise;
            cyc++;
            hs_rise = hsync && !prev_hs;
            vs_rise = vsync && !prev_vs;
            if (vs_rise)
                chk(hs_rise, "R4 vsync start off line start", hs_rise, 1);
            if (hs_rise) begin
                if (have_line) begin
                    chk(cyc - last_hs == HTOT, "R2 line period", cyc - last_hs, HTOT);
                    // R3 / R5 count of active samples on the line just ended
                    chk(de_cnt == ((lidx >= VBLANK) ? ACT_W : 0), "R3 R5 de count per line",
                        de_cnt, (lidx >= VBLANK) ? ACT_W : 0);
                    if (de_cnt == ACT_W) act_lines++;
                end
                if (vs_rise) begin
                    if (have_field) begin
                        chk(lidx == VTOT - 1, "R4 lines per field", lidx + 1, VTOT);
                        chk(cyc - last_vs == HTOT * VTOT, "R4 field period", cyc - last_vs, HTOT * VTOT);
                        chk(act_lines == FLINES, "R5 active lines per field", act_lines, FLINES);
                        fld_exp = ~fld_exp;
                    end else begin
                        fld_exp = 1'b0;
                    end
                    chk(field == fld_exp, "R6 field level at vsync", field, fld_exp);
                    have_field = 1;
                    fields++;
                    lidx = 0;
                    act_lines = 0;
                    last_vs = cyc;
                end else begin
                    lidx++;
                end
                have_line = 1;
                hpos = 0;
                de_cnt = 0;
                last_hs = cyc;
            end
            if (!hsync && prev_hs)
                chk(cyc - last_hs == HS_W, "R2 hsync width", cyc - last_hs, HS_W);
            if (!vsync && prev_vs)
                chk(cyc - last_vs == VS_W, "R4 vsync width", cyc - last_vs, VS_W);
            if (have_field && !vs_rise)
                chk(field == fld_exp, "R6 field stable within field", field, fld_exp);
            if (have_line) begin
                if (de) begin
                    int fl;
                    int ecb;
                    chk(hpos == HBLANK + de_cnt, "R3 de position", hpos, HBLANK + de_cnt);
                    chk(lidx >= VBLANK, "R5 de in blank line", lidx, VBLANK);
                    fl = 2 * (lidx - VBLANK) + int'(fld_exp);
                    ecb = ((de_cnt % 2) ? 8'hC0 : 8'h40) | (fl & 6'h3F);
                    chk(int'(chroma) == ecb, "R8 chroma sample", chroma, ecb);
                    chk(int'(luma) == ((de_cnt + fl) % 256), "R9 luma sample", luma, (de_cnt + fl) % 256);
                    de_cnt++;
                end else begin
                    chk(luma == 8'h10, "R7 blank luma", luma, 8'h10);
                    chk(chroma == 8'h80, "R7 blank chroma", chroma, 8'h80);
                end
            end
            hpos++;
            prev_hs = hsync;
            prev_vs = vsync;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1 reset state
        chk(hsync == 1'b0, "R1 hsync in reset", hsync, 0);
        chk(vsync == 1'b0, "R1 vsync in reset", vsync, 0);
        chk(de == 1'b0, "R1 de in reset", de, 0);
        chk(field == 1'b0, "R1 field in reset", field, 0);
        chk(luma == 8'h10, "R1 luma in reset", luma, 8'h10);
        chk(chroma == 8'h80, "R1 chroma in reset", chroma, 8'h80);
        rst_n = 1'b1;
        mon_en = 1'b1;
        repeat (HTOT * VTOT * 5 + 20) @(negedge clk);
        chk(fields >= 5, "R6 fields seen", fields, 5);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(5 * 20000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", fields, 5);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule